// File: doc/BRIEF.md
# Frame DMA Channel Arbiter

This block decides, every clock cycle, which of eight frame DMA channels may move one data beat over a shared memory path toward one of two CPU ports. Channels 0 to 5 carry injection traffic, and each one is steered to port 0 or port 1 by its own configuration bit. Channel 6 carries extraction traffic for port 0 and channel 7 carries extraction traffic for port 1. Neither extraction channel can be moved to the other port.

Within one port the winner is chosen by strict priority. Once a channel has started a frame on a port, it holds that port until it finishes the frame. Across the two ports a two-entry round-robin pointer alternates turns. A port that has nothing to send, or that is not ready, gives up its turn so that the other port can proceed.

Each port runs a small ownership state machine with two states:
- `PS_IDLE`: no frame is in progress. The port offers its highest-priority eligible channel.
- `PS_OWNED`: a frame is in progress. The port offers only its owner channel.

The port moves from `PS_IDLE` to `PS_OWNED` on a granted beat that carries start-of-frame but not end-of-frame. It moves from `PS_OWNED` back to `PS_IDLE` on a granted beat of the owner that carries end-of-frame.

The round-robin pointer has two states, `RR_PORT0` and `RR_PORT1`. After every granted beat it moves to the port that was not granted.

Top module: `fdma_chan_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no grant is issued. All ports start in `PS_IDLE` and the pointer starts in `RR_PORT0`, so the first time both ports contend, port 0 wins.
- R2: Port routing works as follows:
  - An injection channel c (0 to 5) competes on port 0 when `inj_port_sel[c]` is 0 and on port 1 when it is 1.
  - Channel 6 only ever competes on port 0.
  - Channel 7 only ever competes on port 1.
- R3: On a port in `PS_IDLE`, the winner among channels that are enabled and requesting is chosen as follows: an extraction channel beats any injection channel, and between two channels of the same kind the higher channel number wins.
- R4: A granted beat with `ch_sof` set and `ch_eof` clear locks the port to that channel. Until the owner's own granted beat with `ch_eof` set, only the owner is granted on that port, even when higher-priority channels request. An end-of-frame strobe on a beat that is not granted releases nothing.
- R5: A granted beat with both `ch_sof` and `ch_eof` set is a single-beat frame and leaves the port in `PS_IDLE`.
- R6: When both ports have a grantable channel, the pointer's port is granted. After every granted beat, the pointer moves to the port that was not granted.
- R7: A port with no eligible channel, with `port_rdy` low, or whose owner is not requesting is skipped. In that case the other port is granted if it can be, and no cycle is wasted.
- R8: `ch_en` and `inj_port_sel` are registered. A change to either takes effect one cycle after it is applied, and a channel that is disabled or re-routed while it owns no port leaves arbitration at that point.
- R9: An owner keeps its port until the end of its frame even if its port-select bit changes. The new routing applies once the frame is over. A channel that owns one port is not offered on the other port.
- R10: At most one bit of `port_gnt` is set in a cycle, at bit `port*8 + channel`. The global signals `gnt_vld`, `gnt_ch` and `gnt_port` describe that bit, and `gnt_ext` is 1 exactly when the granted channel is 6 or 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | 8 | Per-channel enable (registered) |
| ch_req | input | 8 | Per-channel beat request |
| ch_sof | input | 8 | Start-of-frame marker on the current beat |
| ch_eof | input | 8 | End-of-frame marker on the current beat |
| inj_port_sel | input | 6 | Target port of each injection channel (registered) |
| port_rdy | input | 2 | Port can accept a beat this cycle |
| port_gnt | output | 16 | Per-port grant vectors, bit port*8+channel |
| gnt_vld | output | 1 | A beat is granted this cycle |
| gnt_ch | output | 3 | Granted channel |
| gnt_port | output | 1 | Granted port |
| gnt_ext | output | 1 | Granted channel is an extraction channel |

## Verification
The bench targets the following corner cases:
- **Configuration latency (R8).** It checks the cycle right after a change to enable or routing. A design that used the raw configuration would grant, or still route the old way, one cycle too early.
- **Ownership (R4, R9).** It locks a port and then raises a higher-priority extraction request, lets the owner go quiet, and moves the owner's port bit mid-frame. A design with a broken lock would let the extraction channel in, release the port on an ungranted end-of-frame strobe, or grant the re-routed owner on both ports.
- **Single-beat frames (R5).** A design that locked on them would starve the next channel.
- **Port fairness (R6, R7).** The bench runs alternation under steady contention and skips a port whose `port_rdy` is low. A pointer that did not flip, or that did not skip a blocked port, would grant the same port twice in a row or stall.

// File: rtl/fdma_arb_pkg.sv
package fdma_arb_pkg;

    // The round-robin stage is a two-entry pointer, so the port count is fixed here.
    localparam int unsigned NUM_PORT = 2;
    localparam int unsigned NUM_EXT  = NUM_PORT;

    typedef enum logic [0:0] {
        PS_IDLE  = 1'b0,
        PS_OWNED = 1'b1
    } port_state_e;

    typedef enum logic [0:0] {
        RR_PORT0 = 1'b0,
        RR_PORT1 = 1'b1
    } rr_state_e;

endpackage

// File: rtl/fdma_arb_map.sv
module fdma_arb_map
    import fdma_arb_pkg::*;
#(
    parameter int unsigned NUM_INJ = 6,
    localparam int unsigned NUM_CH = NUM_INJ + NUM_EXT
) (
    input  logic [NUM_INJ-1:0]         sel_q,
    output logic [NUM_PORT*NUM_CH-1:0] route
);

    // route[p*NUM_CH + c] is set when channel c competes on port p.
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            if (c < NUM_INJ) begin : g_inj
                // Injection channel: follows its own port-select bit.
                assign route[p*NUM_CH + c] = (sel_q[c] == 1'(p));
            end else begin : g_ext
                // Extraction channel: tied to the port with the same offset.
                assign route[p*NUM_CH + c] = ((c - NUM_INJ) == p);
            end
        end
    end

endmodule

// File: rtl/fdma_arb_port.sv
module fdma_arb_port
    import fdma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] elig,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] sof,
    input  logic [NUM_CH-1:0] eof,
    input  logic              win,
    output logic              cand_vld,
    output logic [CH_W-1:0]   cand_ch,
    output logic [NUM_CH-1:0] owner_mask
);

    port_state_e     st_q, st_d;
    logic [CH_W-1:0] own_q, own_d;

    // Extraction channels sit at the top indices, so "highest set index"
    // means extraction first, then the higher number within each kind.
    function automatic logic [CH_W-1:0] top_pick(input logic [NUM_CH-1:0] v);
        logic [CH_W-1:0] r;
        r = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (v[c]) r = CH_W'(c);
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PS_IDLE;
            own_q <= '0;
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        own_d = own_q;
        unique case (st_q)
            PS_IDLE: begin
                if (win && sof[cand_ch] && !eof[cand_ch]) begin
                    st_d  = PS_OWNED;
                    own_d = cand_ch;
                end
            end
            PS_OWNED: begin
                if (win && eof[own_q]) begin
                    st_d = PS_IDLE;
                end
            end
            default: st_d = PS_IDLE;
        endcase
    end

    always_comb begin
        cand_vld   = 1'b0;
        cand_ch    = '0;
        owner_mask = '0;
        unique case (st_q)
            PS_IDLE: begin
                cand_vld = |elig;
                cand_ch  = top_pick(elig);
            end
            PS_OWNED: begin
                cand_vld          = req[own_q];
                cand_ch           = own_q;
                owner_mask[own_q] = 1'b1;
            end
            default: begin
                cand_vld = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fdma_arb_rr.sv
module fdma_arb_rr
    import fdma_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PORT-1:0] want,
    output logic [NUM_PORT-1:0] win,
    output logic                any_win
);

    rr_state_e ptr_q, ptr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= RR_PORT0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // Next state: after a granted beat, point at the port that lost.
    always_comb begin
        ptr_d = ptr_q;
        if (any_win) begin
            ptr_d = win[0] ? RR_PORT1 : RR_PORT0;
        end
    end

    // Outputs: the pointed-at port wins if it wants; otherwise the other one.
    always_comb begin
        win = '0;
        unique case (ptr_q)
            RR_PORT0: begin
                win[0] = want[0];
                win[1] = want[1] && !want[0];
            end
            RR_PORT1: begin
                win[1] = want[1];
                win[0] = want[0] && !want[1];
            end
            default: win = '0;
        endcase
        any_win = |win;
    end

endmodule

// File: rtl/fdma_chan_arb.sv
module fdma_chan_arb
    import fdma_arb_pkg::*;
#(
    parameter int unsigned NUM_INJ = 6,
    localparam int unsigned NUM_CH = NUM_INJ + NUM_EXT,
    localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            ch_en,
    input  logic [NUM_CH-1:0]            ch_req,
    input  logic [NUM_CH-1:0]            ch_sof,
    input  logic [NUM_CH-1:0]            ch_eof,
    input  logic [NUM_INJ-1:0]           inj_port_sel,
    input  logic [NUM_PORT-1:0]          port_rdy,
    output logic [NUM_PORT*NUM_CH-1:0]   port_gnt,
    output logic                         gnt_vld,
    output logic [CH_W-1:0]              gnt_ch,
    output logic                         gnt_port,
    output logic                         gnt_ext
);

    logic [NUM_CH-1:0]                en_q;
    logic [NUM_INJ-1:0]               sel_q;
    logic [NUM_PORT*NUM_CH-1:0]       route;
    logic [NUM_PORT-1:0][NUM_CH-1:0]  own_mask;
    logic [NUM_PORT-1:0][CH_W-1:0]    cand_ch;
    logic [NUM_PORT-1:0]              cand_vld;
    logic [NUM_PORT-1:0]              want;
    logic [NUM_PORT-1:0]              win;
    logic                             any_win;
    logic [NUM_CH-1:0]                busy;

    // Configuration is sampled, so changes apply from the following cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else begin
            en_q  <= ch_en;
            sel_q <= inj_port_sel;
        end
    end

    fdma_arb_map #(.NUM_INJ(NUM_INJ)) u_map (
        .sel_q (sel_q),
        .route (route)
    );

    // A channel that owns a port is never offered on another port.
    always_comb begin
        busy = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            busy |= own_mask[p];
        end
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        logic [NUM_CH-1:0] elig;
        assign elig = en_q & ch_req & route[p*NUM_CH +: NUM_CH] & ~busy;

        fdma_arb_port #(.NUM_CH(NUM_CH)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .elig       (elig),
            .req        (ch_req),
            .sof        (ch_sof),
            .eof        (ch_eof),
            .win        (win[p]),
            .cand_vld   (cand_vld[p]),
            .cand_ch    (cand_ch[p]),
            .owner_mask (own_mask[p])
        );

        assign want[p] = cand_vld[p] && port_rdy[p];
        assign port_gnt[p*NUM_CH +: NUM_CH] =
            win[p] ? (NUM_CH'(1) << cand_ch[p]) : '0;
    end

    fdma_arb_rr u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (want),
        .win     (win),
        .any_win (any_win)
    );

    assign gnt_vld  = any_win;
    assign gnt_port = win[1];
    assign gnt_ch   = win[1] ? cand_ch[1] : cand_ch[0];
    assign gnt_ext  = any_win && (gnt_ch >= CH_W'(NUM_INJ));

endmodule

// File: rtl/fdma_chan_arb_chk.sv
module fdma_chan_arb_chk
    import fdma_arb_pkg::*;
#(
    parameter int unsigned NUM_INJ = 6,
    localparam int unsigned NUM_CH = NUM_INJ + NUM_EXT
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CH-1:0]          ch_sof,
    input logic [NUM_CH-1:0]          ch_eof,
    input logic [NUM_PORT*NUM_CH-1:0] port_gnt,
    input logic                       gnt_vld,
    input logic                       gnt_port,
    input logic [NUM_PORT-1:0]        port_want
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!gnt_vld);
        end
    end

    // R10
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_gnt));

    // R10
    gnt_vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld == (|port_gnt));

    // R2
    ext_fixed_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_gnt[NUM_INJ+1] == 1'b0) && (port_gnt[NUM_CH+NUM_INJ] == 1'b0));

    // R7
    no_idle_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_want) |-> gnt_vld);

    // R6
    port_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && (&port_want) && $past(gnt_vld)) |-> (gnt_port != $past(gnt_port)));

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_lock
        logic [NUM_CH-1:0] slice;
        assign slice = port_gnt[p*NUM_CH +: NUM_CH];
        // R4
        frame_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|(slice & ch_sof & ~ch_eof)) |=> ((slice == '0) || (slice == $past(slice))));
    end

endmodule

bind fdma_chan_arb fdma_chan_arb_chk #(.NUM_INJ(NUM_INJ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_sof    (ch_sof),
    .ch_eof    (ch_eof),
    .port_gnt  (port_gnt),
    .gnt_vld   (gnt_vld),
    .gnt_port  (gnt_port),
    .port_want (want)
);

// File: tb/fdma_chan_arb_test.sv
module fdma_chan_arb_test;

    localparam int CLK_P = 10;

    typedef struct {
        logic  vld;
        int    ch;
        int    port;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ch_en = '0, ch_req = '0, ch_sof = '0, ch_eof = '0;
    logic [5:0]  inj_port_sel = '0;
    logic [1:0]  port_rdy = '0;
    logic [15:0] port_gnt;
    logic        gnt_vld, gnt_port, gnt_ext;
    logic [2:0]  gnt_ch;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    fdma_chan_arb uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_en        (ch_en),
        .ch_req       (ch_req),
        .ch_sof       (ch_sof),
        .ch_eof       (ch_eof),
        .inj_port_sel (inj_port_sel),
        .port_rdy     (port_rdy),
        .port_gnt     (port_gnt),
        .gnt_vld      (gnt_vld),
        .gnt_ch       (gnt_ch),
        .gnt_port     (gnt_port),
        .gnt_ext      (gnt_ext)
    );

    task automatic drv(input logic [7:0] en, input logic [5:0] sel,
                       input logic [7:0] req, input logic [7:0] sof,
                       input logic [7:0] eof, input logic [1:0] rdy,
                       input logic ev, input int ech, input int eport,
                       input string tag);
        exp_t e;
        @(negedge clk);
        ch_en        = en;
        inj_port_sel = sel;
        ch_req       = req;
        ch_sof       = sof;
        ch_eof       = eof;
        port_rdy     = rdy;
        e.vld  = ev;
        e.ch   = ech;
        e.port = eport;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares a quarter period after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (sb.size() != 0) begin
                exp_t e;
                logic [15:0] ev;
                bit ok;
                e  = sb.pop_front();
                ev = e.vld ? (16'd1 << (e.port*8 + e.ch)) : 16'd0;
                ok = (port_gnt == ev) && (gnt_vld == e.vld);
                if (e.vld) begin
                    ok = ok && (int'(gnt_ch) == e.ch) && (int'(gnt_port) == e.port)
                            && (gnt_ext == (e.ch >= 6));
                end
                n_chk++;
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s: got gnt=%h vld=%0b ch=%0d port=%0d ext=%0b, expected gnt=%h",
                             e.tag, port_gnt, gnt_vld, gnt_ch, gnt_port, gnt_ext, ev);
                end
            end
        end
    end

    initial begin
        #(CLK_P*5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: quiet while in reset
        drv(8'hFF, 6'h00, 8'hFF, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R1 reset");
        drv(8'hFF, 6'h00, 8'hFF, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R1 reset");
        drv(8'h00, 6'h00, 8'h00, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R1 reset");
        rst_n = 1'b1;
        // R8: enable not yet visible
        drv(8'hFF, 6'h00, 8'h81, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R8 enable latency");
        // R1: pointer starts at port 0; R2 routing
        drv(8'hFF, 6'h00, 8'h81, 8'h00, 8'h00, 2'b11, 1'b1, 0, 0, "R1 first turn port0");
        drv(8'hFF, 6'h00, 8'h81, 8'h00, 8'h00, 2'b11, 1'b1, 7, 1, "R6 alternate to port1");
        // R3: priority
        drv(8'hFF, 6'h00, 8'h4F, 8'h00, 8'h00, 2'b11, 1'b1, 6, 0, "R3 extraction first");
        drv(8'hFF, 6'h00, 8'h0F, 8'h00, 8'h00, 2'b11, 1'b1, 3, 0, "R3 higher number");
        // R8: re-route not yet visible
        drv(8'hFF, 6'h20, 8'h21, 8'h00, 8'h00, 2'b11, 1'b1, 5, 0, "R8 select latency");
        drv(8'hFF, 6'h20, 8'h21, 8'h00, 8'h00, 2'b11, 1'b1, 5, 1, "R2 sel=1 to port1");
        drv(8'hFF, 6'h20, 8'h21, 8'h00, 8'h00, 2'b11, 1'b1, 0, 0, "R6 alternate");
        drv(8'hFF, 6'h20, 8'h21, 8'h00, 8'h00, 2'b11, 1'b1, 5, 1, "R6 alternate");
        // R7: port0 not ready, pointer at port0
        drv(8'hFF, 6'h20, 8'h21, 8'h00, 8'h00, 2'b10, 1'b1, 5, 1, "R7 skip unready");
        drv(8'hFF, 6'h20, 8'h21, 8'h00, 8'h00, 2'b11, 1'b1, 0, 0, "R6 after skip");
        // R4: lock port0 to ch1
        drv(8'hFF, 6'h20, 8'h03, 8'h02, 8'h00, 2'b11, 1'b1, 1, 0, "R4 frame start");
        drv(8'hFF, 6'h20, 8'h43, 8'h00, 8'h00, 2'b11, 1'b1, 1, 0, "R4 owner beats ch6");
        drv(8'hFF, 6'h20, 8'h61, 8'h00, 8'h00, 2'b11, 1'b1, 5, 1, "R7 owner idle skip");
        // R9: owner re-routed mid frame
        drv(8'hFF, 6'h22, 8'h41, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R4 port held");
        drv(8'hFF, 6'h22, 8'h42, 8'h00, 8'h02, 2'b11, 1'b1, 1, 0, "R9 owner keeps port");
        drv(8'hFF, 6'h22, 8'h42, 8'h00, 8'h00, 2'b11, 1'b1, 1, 1, "R9 new route after eof");
        // R5: single-beat frame
        drv(8'hFF, 6'h22, 8'h40, 8'h40, 8'h40, 2'b11, 1'b1, 6, 0, "R5 single beat");
        drv(8'hFF, 6'h22, 8'h01, 8'h00, 8'h00, 2'b11, 1'b1, 0, 0, "R5 no lock left");
        // R8: disable
        drv(8'hFE, 6'h22, 8'h01, 8'h00, 8'h00, 2'b11, 1'b1, 0, 0, "R8 disable latency");
        drv(8'hFE, 6'h22, 8'h01, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R8 disabled");
        // R4 on port1 with ch7
        drv(8'hFE, 6'h22, 8'h80, 8'h00, 8'h00, 2'b11, 1'b1, 7, 1, "R2 ch7 port1");
        drv(8'hFE, 6'h22, 8'h80, 8'h80, 8'h00, 2'b11, 1'b1, 7, 1, "R4 frame start p1");
        drv(8'hFE, 6'h22, 8'hC0, 8'h00, 8'h00, 2'b11, 1'b1, 6, 0, "R6 both ports");
        drv(8'hFE, 6'h22, 8'hC0, 8'h00, 8'h00, 2'b11, 1'b1, 7, 1, "R6 both ports");
        drv(8'hFE, 6'h22, 8'hC0, 8'h00, 8'h80, 2'b11, 1'b1, 6, 0, "R4 ungranted eof");
        drv(8'hFE, 6'h22, 8'h02, 8'h00, 8'h00, 2'b11, 1'b0, 0, 0, "R4 still locked");
        drv(8'hFE, 6'h22, 8'h80, 8'h00, 8'h80, 2'b11, 1'b1, 7, 1, "R4 frame end");
        drv(8'hFE, 6'h22, 8'h02, 8'h00, 8'h00, 2'b11, 1'b1, 1, 1, "R4 released");
        drv(8'h00, 6'h00, 8'h00, 8'h00, 8'h00, 2'b00, 1'b0, 0, 0, "R10 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule